// File: doc/BRIEF.md
# Clock Routing and Suspend Controller

This block takes four internal clock sources and drives six clock outputs from them. The sources are the reference and three PLLs. Each source is presented as a single-cycle tick on a shared system clock. Four general outputs each pick any source through a 2-bit crosspoint code and divide it with a programmable counter. A fifth output divides PLL1 by 2, 3 or 4. A sixth output buffers the reference tick without dividing it.

Two pins control power. The output-enable/shutdown pin three-states every output when it is low. If full stop is configured, that same low level also drops the PLL enables and the oscillator enable and clears every counter. The suspend pin, when low, shuts off a configured set of PLLs and outputs. The PLL mask is checked against the routing. Any output fed by a suspended PLL is forced into suspend, and a configuration-error flag reports that the output mask was incomplete.

After a full stop, every output that uses a PLL stays three-stated until that PLL reports lock again.

Top module: `clkrt_top`

## Requirements
- R1: For output k, the code in `cfg_sel[2k+1:2k]` selects its source: 0 is the reference, 1 is PLL1, 2 is PLL2 and 3 is PLL3. The `src_tick` bits are indexed with the same codes.
- R2: Each general output toggles on every N-th tick of its source, where N is its `cfg_div` field and a value of 0 acts as 1. A tick is counted only while the source is running. If the count is already at or beyond N-1 when a tick arrives, the output toggles and the count restarts.
- R3: The PLL1 post divider counts 0 to M-1 on PLL1 ticks. `cfg_post_sel` code 0 gives M=2, code 1 gives M=3, and codes 2 and 3 give M=4. `post_out` is high while the count is below floor(M/2).
- R4: `ref_out` equals `src_tick[0]` while the oscillator is enabled, and is 0 otherwise.
- R5: While `oe_sd` is low, every output enable is low in the same cycle.
- R6: While `oe_sd` is low and `cfg_full_stop` is 1, `pll_en` and `osc_en` are 0. On the next edge every counter and every divided output returns to zero phase, which makes `clk_out` 0.
- R7: While `susp_n` is low, `pll_en[i]` is 0 for each set bit of `cfg_susp_pll`. The enable of each output whose `cfg_susp_out` bit is set is also 0. In that mask, bits 0 to 3 are the general outputs, bit 4 is the post divider and bit 5 is the reference buffer.
- R8: A divider whose source PLL is disabled holds its count and its output level.
- R9: An output whose source is a PLL in `cfg_susp_pll` is suspended even if its own mask bit is clear. The post output counts as sourced from PLL1. `cfg_err` is 1 whenever such an output has its mask bit clear, whatever the level of `susp_n`.
- R10: Every cycle of full stop arms a relock flag for each PLL. A flag clears on the first edge on which its `pll_lock` bit is seen high. Any output sourced from a PLL whose flag is armed has its enable held at 0.
- R11: Reset clears all counters, divided levels and relock flags. After reset `clk_out` is 0 and `post_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 4 | Source ticks: bit 0 reference, bits 1..3 PLL1..PLL3 |
| pll_lock | input | 3 | Lock-ready per PLL |
| oe_sd | input | 1 | Output enable / shutdown, active low |
| susp_n | input | 1 | Suspend, active low |
| cfg_full_stop | input | 1 | Low `oe_sd` also stops PLLs, oscillator and counters |
| cfg_sel | input | 2*NUM_OUT | Crosspoint code per general output |
| cfg_div | input | DIV_W*NUM_OUT | Divide value per general output |
| cfg_post_sel | input | 2 | PLL1 post divider ratio code |
| cfg_susp_pll | input | 3 | PLLs shut off during suspend |
| cfg_susp_out | input | NUM_OUT+2 | Outputs shut off during suspend |
| clk_out | output | NUM_OUT | General divided outputs |
| clk_oe | output | NUM_OUT | Drive enables of the general outputs |
| post_out | output | 1 | PLL1 post divider output |
| post_oe | output | 1 | Drive enable of the post output |
| ref_out | output | 1 | Buffered reference |
| ref_oe | output | 1 | Drive enable of the reference buffer |
| pll_en | output | 3 | PLL enables |
| osc_en | output | 1 | Oscillator enable |
| cfg_err | output | 1 | Suspend mask misses a dependent output |

## Verification
Enables, `pll_en`, `osc_en`, `cfg_err` and `ref_out` are combinational. They are due in the same cycle as the pin and configuration values that set them. The relock flags add exactly one edge: a lock or a stop sampled at an edge changes the enables just after it. The divided outputs change on the first rising edge that samples a counted tick. The bench therefore sets inputs after the falling edge and checks the combinational results one time unit later. It then advances its own model at the rising edge and compares the divided outputs one time unit after that edge.

// File: rtl/clkrt_pkg.sv
package clkrt_pkg;
    localparam int NUM_SRC = 4;
    localparam int NUM_PLL = 3;
    localparam int SEL_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_REF  = 2'd0,
        SRC_PLL1 = 2'd1,
        SRC_PLL2 = 2'd2,
        SRC_PLL3 = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        POST_DIV2  = 2'd0,
        POST_DIV3  = 2'd1,
        POST_DIV4  = 2'd2,
        POST_DIV4B = 2'd3
    } post_sel_e;
endpackage

// File: rtl/clkrt_chan.sv
module clkrt_chan #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             stop,
    input  logic [DIV_W-1:0] div,
    output logic             level
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tog;
    } chan_st_t;

    chan_st_t         st_d, st_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        st_d  = st_q;
        limit = (div == '0) ? '0 : div - DIV_W'(1);
        if (stop) begin
            st_d = '0;
        end else if (run && tick) begin
            if (st_q.cnt >= limit) begin
                st_d.cnt = '0;
                st_d.tog = ~st_q.tog;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.tog;

    // R6
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (level == 1'b0));

    // R8
    halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop && !run) |=> $stable(level));
endmodule

// File: rtl/clkrt_post.sv
module clkrt_post
    import clkrt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run,
    input  logic       stop,
    input  logic [1:0] sel,
    output logic       level
);
    typedef struct packed {
        logic [1:0] cnt;
    } post_st_t;

    post_st_t   st_d, st_q;
    logic [1:0] last;
    logic [2:0] half;

    always_comb begin
        case (post_sel_e'(sel))
            POST_DIV2: begin last = 2'd1; half = 3'd1; end
            POST_DIV3: begin last = 2'd2; half = 3'd1; end
            default:   begin last = 2'd3; half = 3'd2; end
        endcase
        st_d = st_q;
        if (stop) begin
            st_d = '0;
        end else if (run && tick) begin
            st_d.cnt = (st_q.cnt >= last) ? 2'd0 : st_q.cnt + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = ({1'b0, st_q.cnt} < half);

    // R3
    post_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !stop && st_q.cnt == last) |=> (st_q.cnt == 2'd0));

    // R6
    post_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (level == 1'b1));
endmodule

// File: rtl/clkrt_pwr.sv
module clkrt_pwr
    import clkrt_pkg::*;
#(
    parameter int NUM_OUT = 4,
    localparam int NOUT_ALL = NUM_OUT + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     oe_sd,
    input  logic                     susp_n,
    input  logic                     cfg_full_stop,
    input  logic [SEL_W*NUM_OUT-1:0] cfg_sel,
    input  logic [NUM_PLL-1:0]       cfg_susp_pll,
    input  logic [NOUT_ALL-1:0]      cfg_susp_out,
    input  logic [NUM_PLL-1:0]       pll_lock,
    output logic                     full_stop,
    output logic [NUM_PLL-1:0]       pll_en,
    output logic                     osc_en,
    output logic [NOUT_ALL-1:0]      out_oe,
    output logic                     cfg_err
);
    typedef struct packed {
        logic [NUM_PLL-1:0] pend;
    } pwr_st_t;

    pwr_st_t             st_d, st_q;
    logic [NUM_SRC-1:0]  susp_src, pend_src;
    logic [NOUT_ALL-1:0] need, pend_use, off;

    assign full_stop = !oe_sd && cfg_full_stop;
    assign osc_en    = !full_stop;
    assign pll_en    = {NUM_PLL{!full_stop}} & ~({NUM_PLL{!susp_n}} & cfg_susp_pll);
    assign susp_src  = {cfg_susp_pll, 1'b0};
    assign pend_src  = {st_q.pend, 1'b0};

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_route
        assign need[k]     = susp_src[cfg_sel[SEL_W*k +: SEL_W]];
        assign pend_use[k] = pend_src[cfg_sel[SEL_W*k +: SEL_W]];
    end
    assign need[NUM_OUT]       = cfg_susp_pll[0];
    assign pend_use[NUM_OUT]   = st_q.pend[0];
    assign need[NUM_OUT+1]     = 1'b0;
    assign pend_use[NUM_OUT+1] = 1'b0;

    assign off     = {NOUT_ALL{!susp_n}} & (cfg_susp_out | need);
    assign out_oe  = {NOUT_ALL{oe_sd}} & ~off & ~pend_use;
    assign cfg_err = |(need & ~cfg_susp_out);

    always_comb begin
        st_d = st_q;
        if (full_stop) st_d.pend = '1;
        else           st_d.pend = st_q.pend & ~pll_lock;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10
    relock_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_stop |=> (st_q.pend == {NUM_PLL{1'b1}}));

    // R5
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_sd |-> (out_oe == '0));

    // R9
    post_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!susp_n && cfg_susp_pll[0]) |-> !out_oe[NUM_OUT]);
endmodule

// File: rtl/clkrt_top.sv
module clkrt_top
    import clkrt_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int DIV_W   = 7,
    localparam int NOUT_ALL = NUM_OUT + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_tick,
    input  logic [NUM_PLL-1:0]       pll_lock,
    input  logic                     oe_sd,
    input  logic                     susp_n,
    input  logic                     cfg_full_stop,
    input  logic [SEL_W*NUM_OUT-1:0] cfg_sel,
    input  logic [DIV_W*NUM_OUT-1:0] cfg_div,
    input  logic [1:0]               cfg_post_sel,
    input  logic [NUM_PLL-1:0]       cfg_susp_pll,
    input  logic [NOUT_ALL-1:0]      cfg_susp_out,
    output logic [NUM_OUT-1:0]       clk_out,
    output logic [NUM_OUT-1:0]       clk_oe,
    output logic                     post_out,
    output logic                     post_oe,
    output logic                     ref_out,
    output logic                     ref_oe,
    output logic [NUM_PLL-1:0]       pll_en,
    output logic                     osc_en,
    output logic                     cfg_err
);
    logic                full_stop;
    logic [NOUT_ALL-1:0] out_oe;
    logic [NUM_SRC-1:0]  live_src;

    clkrt_pwr #(.NUM_OUT(NUM_OUT)) u_pwr (
        .clk          (clk),
        .rst_n        (rst_n),
        .oe_sd        (oe_sd),
        .susp_n       (susp_n),
        .cfg_full_stop(cfg_full_stop),
        .cfg_sel      (cfg_sel),
        .cfg_susp_pll (cfg_susp_pll),
        .cfg_susp_out (cfg_susp_out),
        .pll_lock     (pll_lock),
        .full_stop    (full_stop),
        .pll_en       (pll_en),
        .osc_en       (osc_en),
        .out_oe       (out_oe),
        .cfg_err      (cfg_err)
    );

    assign live_src = {pll_en, osc_en};

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_chan
        logic [SEL_W-1:0] sel_k;
        assign sel_k = cfg_sel[SEL_W*k +: SEL_W];
        clkrt_chan #(.DIV_W(DIV_W)) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (src_tick[sel_k]),
            .run  (live_src[sel_k]),
            .stop (full_stop),
            .div  (cfg_div[DIV_W*k +: DIV_W]),
            .level(clk_out[k])
        );
    end

    clkrt_post u_post (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (src_tick[1]),
        .run  (pll_en[0]),
        .stop (full_stop),
        .sel  (cfg_post_sel),
        .level(post_out)
    );

    assign ref_out = src_tick[0] && osc_en;
    assign clk_oe  = out_oe[NUM_OUT-1:0];
    assign post_oe = out_oe[NUM_OUT];
    assign ref_oe  = out_oe[NUM_OUT+1];

    // R4
    ref_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !ref_out);

    // R6
    stop_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_sd && cfg_full_stop) |=> (clk_out == '0));
endmodule

// File: tb/clkrt_top_bench.sv
module clkrt_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NO = 4;
    localparam int DW = 7;

    logic clk = 1'b0;
    logic rst_n;
    logic [3:0] src_tick;
    logic [2:0] pll_lock;
    logic oe_sd, susp_n, full_cfg;
    logic [2*NO-1:0] cfg_sel;
    logic [DW*NO-1:0] cfg_div;
    logic [1:0] post_sel;
    logic [2:0] susp_pll;
    logic [NO+1:0] susp_out;
    logic [NO-1:0] clk_out, clk_oe;
    logic post_out, post_oe, ref_out, ref_oe, osc_en, cfg_err;
    logic [2:0] pll_en;

    int total = 0;
    int bad = 0;
    int m_cnt [NO];
    bit m_tog [NO];
    int m_pc;
    bit [2:0] m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkrt_top #(.NUM_OUT(NO), .DIV_W(DW)) u_clkrt_top (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .pll_lock(pll_lock),
        .oe_sd(oe_sd), .susp_n(susp_n), .cfg_full_stop(full_cfg),
        .cfg_sel(cfg_sel), .cfg_div(cfg_div), .cfg_post_sel(post_sel),
        .cfg_susp_pll(susp_pll), .cfg_susp_out(susp_out),
        .clk_out(clk_out), .clk_oe(clk_oe), .post_out(post_out), .post_oe(post_oe),
        .ref_out(ref_out), .ref_oe(ref_oe), .pll_en(pll_en), .osc_en(osc_en),
        .cfg_err(cfg_err)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int post_half(logic [1:0] s);
        return (s == 2'd0 || s == 2'd1) ? 1 : 2;
    endfunction

    function automatic int post_last(logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 3;
    endfunction

    task automatic step();
        bit full;
        bit [2:0] pe;
        bit [NO+1:0] need, oe_e;
        int s, lim, dv;
        full = !oe_sd && full_cfg;
        for (int i = 0; i < 3; i++) pe[i] = !full && !(!susp_n && susp_pll[i]);
        for (int k = 0; k < NO; k++) begin
            s = int'(cfg_sel[2*k +: 2]);
            need[k] = (s != 0) && susp_pll[s-1];
            oe_e[k] = oe_sd && !(!susp_n && (susp_out[k] || need[k])) && !((s != 0) && m_pend[s-1]);
        end
        need[NO]   = susp_pll[0];
        oe_e[NO]   = oe_sd && !(!susp_n && (susp_out[NO] || need[NO])) && !m_pend[0];
        need[NO+1] = 1'b0;
        oe_e[NO+1] = oe_sd && !(!susp_n && susp_out[NO+1]);
        #1;
        chk("R6/R7", "pll_en", int'(pll_en), int'(pe));
        chk("R6", "osc_en", int'(osc_en), int'(!full));
        chk("R9", "cfg_err", int'(cfg_err), int'(|(need & ~susp_out)));
        chk("R5/R7/R9/R10", "enables", int'({ref_oe, post_oe, clk_oe}), int'(oe_e));
        chk("R4", "ref_out", int'(ref_out), int'(src_tick[0] && !full));
        @(posedge clk);
        #1;
        for (int k = 0; k < NO; k++) begin
            s = int'(cfg_sel[2*k +: 2]);
            dv = int'(cfg_div[DW*k +: DW]);
            lim = (dv == 0) ? 0 : dv - 1;
            if (full) begin
                m_cnt[k] = 0; m_tog[k] = 0;
            end else if (((s == 0) || pe[s-1]) && src_tick[s]) begin
                if (m_cnt[k] >= lim) begin m_cnt[k] = 0; m_tog[k] = !m_tog[k]; end
                else m_cnt[k]++;
            end
        end
        if (full) m_pc = 0;
        else if (pe[0] && src_tick[1]) m_pc = (m_pc >= post_last(post_sel)) ? 0 : m_pc + 1;
        m_pend = full ? 3'b111 : (m_pend & ~pll_lock);
        for (int k = 0; k < NO; k++)
            chk("R1/R2/R8", "clk_out", int'(clk_out[k]), int'(m_tog[k]));
        chk("R3", "post_out", int'(post_out), int'(m_pc < post_half(post_sel)));
        @(negedge clk);
    endtask

    task automatic rand_cfg();
        cfg_sel  = $urandom;
        for (int k = 0; k < NO; k++) cfg_div[DW*k +: DW] = DW'($urandom_range(0, 5));
        post_sel = $urandom;
        susp_pll = $urandom;
        susp_out = $urandom;
        full_cfg = $urandom;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED);
        rst_n = 1'b0; src_tick = '0; pll_lock = '0; oe_sd = 1'b1; susp_n = 1'b1;
        full_cfg = 1'b0; cfg_sel = '0; cfg_div = '0; post_sel = 2'd0;
        susp_pll = '0; susp_out = '0;
        for (int k = 0; k < NO; k++) begin m_cnt[k] = 0; m_tog[k] = 0; end
        m_pc = 0; m_pend = '0;
        repeat (3) @(negedge clk);
        #1;
        // R11 reset state
        chk("R11", "clk_out reset", int'(clk_out), 0);
        chk("R11", "post_out reset", int'(post_out), 1);
        chk("R11", "enables reset", int'({ref_oe, post_oe, clk_oe}), 6'h3F);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2: each output on a different source, divide by 1..4
        cfg_sel = {2'd3, 2'd2, 2'd1, 2'd0};
        cfg_div = {7'd4, 7'd3, 7'd0, 7'd2};
        src_tick = 4'hF;
        repeat (12) step();

        // R3: post divider /3 then /4
        post_sel = 2'd1;
        src_tick = 4'b0010;
        repeat (7) step();
        post_sel = 2'd3;
        repeat (8) step();

        // R9: output 0 on PLL2 with PLL2 suspended but output mask clear
        cfg_sel[1:0] = 2'd2; susp_pll = 3'b010; susp_out = '0;
        susp_n = 1'b0; src_tick = 4'hF;
        #1;
        chk("R9", "cfg_err directed", int'(cfg_err), 1);
        chk("R9", "forced suspend", int'(clk_oe[0]), 0);
        repeat (4) step();
        susp_n = 1'b1;
        repeat (2) step();

        // R6 R10: full stop, then relock one PLL at a time
        full_cfg = 1'b1; oe_sd = 1'b0; susp_pll = '0;
        cfg_sel = {2'd3, 2'd2, 2'd1, 2'd0};
        repeat (3) step();
        oe_sd = 1'b1; pll_lock = 3'b000;
        repeat (3) step();
        #1;
        chk("R10", "PLL1 output held off", int'(clk_oe[1]), 0);
        chk("R10", "ref output on", int'(clk_oe[0]), 1);
        pll_lock = 3'b001;
        step();
        pll_lock = 3'b110;
        repeat (4) step();

        // Random phase
        for (int blk = 0; blk < 20; blk++) begin
            rand_cfg();
            for (int c = 0; c < 200; c++) begin
                src_tick = $urandom;
                pll_lock = (($urandom % 3) == 0) ? 3'($urandom) : 3'b000;
                oe_sd    = (($urandom % 20) != 0);
                susp_n   = (($urandom % 5) != 0);
                step();
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule